// File: doc/BRIEF.md
# Single-Wire Debug Link Host

This block is the host end of a one-wire, open-drain debug link to a target microcontroller. It moves whole bytes across the wire in either direction. To transmit, it shifts a byte out with the most significant bit first. Each bit cell starts with the host pulling the wire low, and the length of that low pulse encodes the bit value. To receive, it strobes the wire low briefly in each cell and then lets it float. The target either holds the wire low to send a zero or leaves it to the pull-up to send a one. The host samples the wire at a fixed point in the cell.

All bit timing is counted in target debug cycles. A programmable clock-enable divider produces those cycles from the system clock, with one debug cycle equal to `divCfg + 1` clocks. When a transmitted byte ends, the host clears its acknowledge flags and starts watching the wire for the rising edge that ends the target's acknowledge pulse. If that edge does not arrive within `ackLimit` debug cycles, the host raises a timeout flag instead.

A controller above this block issues one byte operation at a time with `txStart` or `rxStart` while `busy` is low. It then waits for the one-cycle `done` pulse. The wire itself is built outside the block from `lineOe`, `lineOut` and `lineIn`.

Top module: `dbgwire_host`

## Requirements
- R1: A transmitted byte is sent as 8 cells, with bit 7 in the first cell and bit 0 in the last.
- R2: Each transmit cell lasts 16 debug cycles. The wire is driven low for the first 4 cycles of a cell for a one, or the first 13 cycles for a zero, and is driven high for the rest of the cell.
- R3: `lineOe` is high only while a byte is being transmitted or a receive strobe is active. During a transmit it stays high for exactly 128 debug cycles and drops at the end of the last cell.
- R4: Each receive cell starts with the host driving the wire low (`lineOe`=1, `lineOut`=0) for exactly 4 debug cycles, after which it releases the wire (`lineOe`=0).
- R5: In each receive cell the host samples the wire, through a two-flop synchroniser, 10 debug cycles after the falling edge. Each sample is shifted into `rxData` at bit 0, so the first bit received ends up in bit 7.
- R6: When a transmitted byte ends, `ackSeen` and `ackTimeout` are cleared in the same cycle as `done`, and acknowledge watching is armed. A later rising edge on the wire sets `ackSeen`. The flag stays clear while the target holds the wire low.
- R7: If no rising edge arrives within `ackLimit` debug cycles after the end of a transmitted byte, `ackTimeout` is set and `ackSeen` stays clear. `ackLimit` must be at least 1.
- R8: One debug cycle lasts `divCfg + 1` clocks, so a transmit cell lasts 16 × (`divCfg` + 1) clocks.
- R9: `busy` is high from the clock after a start until the byte ends. `done` is a single-cycle pulse in the cycle where `busy` falls.
- R10: After reset, `lineOe`, `busy`, `done`, `ackSeen` and `ackTimeout` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divCfg | input | DIV_W | Clocks per debug cycle minus one |
| ackLimit | input | TO_W | Acknowledge timeout in debug cycles |
| txStart | input | 1 | Start transmitting `txData` (while idle) |
| txData | input | 8 | Byte to transmit |
| rxStart | input | 1 | Start receiving a byte (while idle) |
| lineIn | input | 1 | Asynchronous wire level |
| lineOe | output | 1 | Wire driver enable |
| lineOut | output | 1 | Level driven when enabled |
| busy | output | 1 | Byte operation in progress |
| done | output | 1 | One-cycle end-of-byte pulse |
| rxData | output | 8 | Last received byte |
| ackSeen | output | 1 | Acknowledge edge captured |
| ackTimeout | output | 1 | Acknowledge window expired |

## Verification
The hardest case to reach from the ports is the acknowledge watcher. The target's low pulse has to begin only after the host has released the wire. The capture must then happen on the release edge, not on the falling edge. The flag set by one transmit must also be cleared by the next one.

The bench models the wire as a wired-AND of the host driver and two target pull-downs. A target process decodes the host's falling edges and answers receive strobes bit by bit. A second target task produces an acknowledge pulse timed in debug cycles after `done`. The bench samples `ackSeen` just before that pulse ends and again just after it ends. The timeout is bracketed the same way, two debug cycles either side of `ackLimit`. These runs are repeated with the divider at three settings.

// File: rtl/dbgwire_pkg.sv
`timescale 1ns/1ps
package dbgwire_pkg;
  localparam int BITS       = 8;
  localparam int BIDX_W     = $clog2(BITS);
  localparam int CELL_TICKS = 16;
  localparam int PH_W       = $clog2(CELL_TICKS);
  localparam int ONE_LOW    = 4;
  localparam int ZERO_LOW   = 13;
  localparam int STROBE_LOW = 4;
  localparam int SAMPLE_AT  = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX} state_t;

  typedef struct packed {
    logic divRestart;
    logic loadTx;
    logic clrRx;
    logic shiftOut;
    logic sampleIn;
  } strobe_t;
endpackage

// File: rtl/dbgwire_datapath.sv
`timescale 1ns/1ps
module dbgwire_datapath
  import dbgwire_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divCfg,
  input  logic [BITS-1:0]  txData,
  input  logic             lineIn,
  input  strobe_t          stb,
  output logic             tick,
  output logic             txMsb,
  output logic             lineRise,
  output logic [BITS-1:0]  rxByte
);
  logic [DIV_W-1:0] divCnt;
  logic [BITS-1:0]  txShift;
  logic             syncA, syncB, syncPrev;

  // clock-enable divider: one tick per debug cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divCnt <= '0;
    else if (stb.divRestart || divCnt == '0) divCnt <= divCfg;
    else divCnt <= divCnt - 1'b1;
  end
  assign tick = (divCnt == '0) && !stb.divRestart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txShift <= '0;
    else if (stb.loadTx) txShift <= txData;
    else if (stb.shiftOut) txShift <= {txShift[BITS-2:0], 1'b0};
  end
  assign txMsb = txShift[BITS-1];

  // two-flop synchroniser plus one stage for edge detection; idle wire is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
      syncPrev <= 1'b1;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      syncPrev <= syncB;
    end
  end
  assign lineRise = syncB && !syncPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rxByte <= '0;
    else if (stb.clrRx) rxByte <= '0;
    else if (stb.sampleIn) rxByte <= {rxByte[BITS-2:0], syncB};
  end
endmodule

// File: rtl/dbgwire_control.sv
`timescale 1ns/1ps
module dbgwire_control
  import dbgwire_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            txStart,
  input  logic            rxStart,
  input  logic            tick,
  input  logic            txMsb,
  input  logic            lineRise,
  input  logic [TO_W-1:0] ackLimit,
  output strobe_t         stb,
  output logic            lineOe,
  output logic            lineOut,
  output logic            busy,
  output logic            done,
  output logic            ackSeen,
  output logic            ackTimeout
);
  state_t            state;
  logic [PH_W-1:0]   phase;
  logic [BIDX_W-1:0] bitIdx;
  logic              ackArmed;
  logic [TO_W-1:0]   ackCnt;
  logic              cellEnd, lastBit, txLow;

  assign cellEnd = tick && (phase == PH_W'(CELL_TICKS - 1));
  assign lastBit = (bitIdx == BIDX_W'(BITS - 1));
  assign txLow   = txMsb ? (phase < PH_W'(ONE_LOW)) : (phase < PH_W'(ZERO_LOW));

  always_comb begin
    stb = '0;
    if (state == ST_IDLE) begin
      stb.divRestart = txStart || rxStart;
      stb.loadTx     = txStart;
      stb.clrRx      = rxStart && !txStart;
    end
    stb.shiftOut = (state == ST_TX) && cellEnd;
    stb.sampleIn = (state == ST_RX) && tick && (phase == PH_W'(SAMPLE_AT - 1));
  end

  assign lineOe  = (state == ST_TX) || ((state == ST_RX) && (phase < PH_W'(STROBE_LOW)));
  assign lineOut = (state == ST_TX) && !txLow;
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= '0;
      bitIdx <= '0;
      done <= 1'b0;
      ackArmed <= 1'b0;
      ackCnt <= '0;
      ackSeen <= 1'b0;
      ackTimeout <= 1'b0;
    end else begin
      done <= 1'b0;
      // acknowledge watcher, overridden below by a start or a byte end
      if (ackArmed) begin
        if (lineRise) begin
          ackSeen <= 1'b1;
          ackArmed <= 1'b0;
        end else if (tick) begin
          ackCnt <= ackCnt + TO_W'(1);
          if (ackCnt + TO_W'(1) == ackLimit) begin
            ackTimeout <= 1'b1;
            ackArmed <= 1'b0;
          end
        end
      end
      case (state)
        ST_IDLE: begin
          if (txStart || rxStart) begin
            state <= txStart ? ST_TX : ST_RX;
            phase <= '0;
            bitIdx <= '0;
            ackArmed <= 1'b0;
          end
        end
        default: begin
          if (tick) phase <= phase + 1'b1;
          if (cellEnd) begin
            bitIdx <= bitIdx + 1'b1;
            if (lastBit) begin
              state <= ST_IDLE;
              done <= 1'b1;
              if (state == ST_TX) begin
                ackArmed <= 1'b1;
                ackSeen <= 1'b0;
                ackTimeout <= 1'b0;
                ackCnt <= '0;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dbgwire_host.sv
`timescale 1ns/1ps
module dbgwire_host
  import dbgwire_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divCfg,
  input  logic [TO_W-1:0]  ackLimit,
  input  logic             txStart,
  input  logic [BITS-1:0]  txData,
  input  logic             rxStart,
  input  logic             lineIn,
  output logic             lineOe,
  output logic             lineOut,
  output logic             busy,
  output logic             done,
  output logic [BITS-1:0]  rxData,
  output logic             ackSeen,
  output logic             ackTimeout
);
  strobe_t stb;
  logic    tick, txMsb, lineRise;

  dbgwire_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .divCfg(divCfg), .txData(txData), .lineIn(lineIn),
    .stb(stb), .tick(tick), .txMsb(txMsb), .lineRise(lineRise), .rxByte(rxData)
  );

  dbgwire_control #(.TO_W(TO_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .txStart(txStart), .rxStart(rxStart), .tick(tick),
    .txMsb(txMsb), .lineRise(lineRise), .ackLimit(ackLimit), .stb(stb),
    .lineOe(lineOe), .lineOut(lineOut), .busy(busy), .done(done),
    .ackSeen(ackSeen), .ackTimeout(ackTimeout)
  );
endmodule

// File: rtl/dbgwire_host_checker.sv
`timescale 1ns/1ps
module dbgwire_host_checker (
  input logic clk,
  input logic rst_n,
  input logic lineOe,
  input logic busy,
  input logic done,
  input logic ackSeen,
  input logic ackTimeout
);
  assert_oe_in_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lineOe |-> busy);
  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ack_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ackSeen) |-> !busy);
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ackSeen && ackTimeout));
endmodule

bind dbgwire_host dbgwire_host_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lineOe(lineOe), .busy(busy), .done(done),
  .ackSeen(ackSeen), .ackTimeout(ackTimeout)
);

// File: tb/test_dbgwire_host.sv
`timescale 1ns/1ps
module test_dbgwire_host;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] divCfg = 8'd3;
  logic [15:0] ackLimit = 16'd1000;
  logic txStart = 1'b0, rxStart = 1'b0;
  logic [7:0] txData = 8'h00;
  logic lineOe, lineOut, busy, done, ackSeen, ackTimeout;
  logic [7:0] rxData;
  logic rxPull = 1'b0, ackPull = 1'b0;
  logic lineWire;

  assign lineWire = (lineOe ? lineOut : 1'b1) & ~rxPull & ~ackPull;

  dbgwire_host i_dbgwire_host (
    .clk(clk), .rst_n(rst_n), .divCfg(divCfg), .ackLimit(ackLimit),
    .txStart(txStart), .txData(txData), .rxStart(rxStart), .lineIn(lineWire),
    .lineOe(lineOe), .lineOut(lineOut), .busy(busy), .done(done),
    .rxData(rxData), .ackSeen(ackSeen), .ackTimeout(ackTimeout)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0, nBad = 0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic txMode = 1'b0, rxMode = 1'b0;
  logic [7:0] rxPat = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dc();
    return int'(divCfg) + 1;
  endfunction

  // monitor and target model, sampling on the falling clock edge
  int lowCnt = 0, cellCnt = 0, oeCnt = 0, strobeCnt = 0, holdCnt = 0;
  int bitsInByte = 0, rxBit = 0;
  logic [7:0] txAcc = 8'h00;
  logic prevWire = 1'b1, prevOe = 1'b0;

  always @(negedge clk) begin
    if (txMode) begin
      if (lineOe && prevWire && !lineWire) begin
        if (bitsInByte != 0) check(cellCnt == 16 * dc(), "R8 cell length", cellCnt, 16 * dc());
        cellCnt = 0;
      end
      if (lineOe) begin
        cellCnt++;
        oeCnt++;
      end
      if (lineOe && !lineWire) lowCnt++;
      if (lineOe && !prevWire && lineWire) begin
        check(lowCnt == 4 * dc() || lowCnt == 13 * dc(), "R2 low width", lowCnt, 4 * dc());
        txAcc = {txAcc[6:0], (lowCnt == 4 * dc())};
        lowCnt = 0;
        bitsInByte++;
        if (bitsInByte == 8) begin
          bitsInByte = 0;
          if (txQ.size() == 0) check(0, "R1 unexpected byte", txAcc, 0);
          else begin
            logic [7:0] e;
            e = txQ.pop_front();
            check(txAcc == e, "R1 byte order", txAcc, e);
          end
        end
      end
      if (prevOe && !lineOe) begin
        check(oeCnt == 128 * dc(), "R3 driver window", oeCnt, 128 * dc());
        oeCnt = 0;
      end
      if (done) begin
        check(!ackSeen, "R6 seen cleared", ackSeen, 0);
        check(!ackTimeout, "R6 timeout cleared", ackTimeout, 0);
      end
    end
    if (rxMode) begin
      if (holdCnt > 0) begin
        holdCnt--;
        if (holdCnt == 0) rxPull = 1'b0;
      end
      if (lineOe && lineOut) check(0, "R4 strobe level", 1, 0);
      if (lineOe) strobeCnt++;
      if (prevOe && !lineOe) begin
        check(strobeCnt == 4 * dc(), "R4 strobe width", strobeCnt, 4 * dc());
        strobeCnt = 0;
      end
      if (lineOe && prevWire && !lineWire) begin
        if (!rxPat[7 - rxBit]) begin
          rxPull = 1'b1;
          holdCnt = 13 * dc();
        end
        rxBit++;
      end
      if (done) begin
        if (rxQ.size() == 0) check(0, "R5 unexpected byte", rxData, 0);
        else begin
          logic [7:0] e;
          e = rxQ.pop_front();
          check(rxData == e, "R5 received byte", rxData, e);
        end
      end
    end
    prevWire = lineWire;
    prevOe = lineOe;
  end

  task automatic doTx(input logic [7:0] d);
    txMode = 1'b1;
    rxMode = 1'b0;
    txQ.push_back(d);
    @(negedge clk);
    txData = d;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    check(busy, "R9 busy after start", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!busy, "R9 busy after done", busy, 0);
  endtask

  task automatic doRx(input logic [7:0] pat);
    txMode = 1'b0;
    rxMode = 1'b1;
    rxPat = pat;
    rxBit = 0;
    rxQ.push_back(pat);
    @(negedge clk);
    rxStart = 1'b1;
    @(negedge clk);
    rxStart = 1'b0;
    check(busy, "R9 busy after start", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ackRun();
    ackLimit = 16'd1000;
    doTx(8'hA5);
    repeat (32 * dc()) @(negedge clk);
    ackPull = 1'b1;
    repeat (16 * dc()) @(negedge clk);
    check(!ackSeen, "R6 no capture while low", ackSeen, 0);
    ackPull = 1'b0;
    repeat (4) @(negedge clk);
    check(ackSeen, "R6 rising edge captured", ackSeen, 1);
    check(!ackTimeout, "R6 no timeout", ackTimeout, 0);
  endtask

  task automatic timeoutRun(input logic [7:0] d);
    ackLimit = 16'd40;
    doTx(d);
    repeat (38 * dc() - 1) @(negedge clk);
    check(!ackTimeout, "R7 early", ackTimeout, 0);
    repeat (4 * dc()) @(negedge clk);
    check(ackTimeout, "R7 expired", ackTimeout, 1);
    check(!ackSeen, "R7 seen stays clear", ackSeen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!lineOe && !busy && !done, "R10 reset outputs", {lineOe, busy, done}, 0);
    check(!ackSeen && !ackTimeout, "R10 reset flags", {ackSeen, ackTimeout}, 0);
    check(lineWire, "R10 wire released", lineWire, 1);

    divCfg = 8'd3;
    ackRun();
    timeoutRun(8'h3C);
    doRx(8'hC3);
    doRx(8'h5A);

    divCfg = 8'd0;
    doTx(8'hFF);
    doTx(8'h00);
    doRx(8'h81);
    ackRun();

    divCfg = 8'd1;
    timeoutRun(8'h96);
    doRx(8'h7E);

    repeat (5) @(negedge clk);
    check(txQ.size() == 0, "R1 all bytes seen", txQ.size(), 0);
    check(rxQ.size() == 0, "R5 all bytes seen", rxQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule